// File: doc/BRIEF.md
# Four-Rail Power Sequencer and Supervisor

This block is the digital controller of a four-rail display supply. It turns on a reference, a main boost rail, a negative rail and a positive rail strictly in that order. Each rail has one enable output. The controller watches two comparator flags per rail: "good", meaning the rail is in regulation, and "below fault", meaning it has dropped under its fault threshold. When the last rail is good, it drives an active-low ready output. The comparators, the regulators and the open-drain ready pad are outside the block. They are seen only as the digital flags and enables at its ports.

A mode input picks between two ways of chaining the rails. In immediate mode, each rail starts as soon as the previous rail reports good. In delayed mode, two of the hand-offs also wait for a minimum number of timing ticks, counted from the moment the upstream rail was enabled. After start-up the block supervises the rails. When a rail faults, every rail after it in the order is dropped and ready is released. Those rails come back through the normal start rules once the faulted rail is good again. An active-low shutdown input clears everything at once.

Rail index used on every vector port: bit 0 reference, bit 1 main boost, bit 2 negative rail, bit 3 positive rail.

Top module: `rail_sequencer`

## Requirements
- R1: A rail's enable (`rail_en[i]`, i = 1..3) is never high unless the enable of rail i-1 is also high.
- R2: The main boost enable (bit 1) rises only after the reference good flag (bit 0) has been seen, through the synchronizer, as set.
- R3: In delayed mode (`delay_mode` = 1), the negative-rail enable (bit 2) rises only when two conditions hold: the main rail is good, and at least MAIN_DLY ticks (default 16) have been counted since the main rail was enabled.
- R4: In delayed mode, the positive-rail enable (bit 3) rises only when two conditions hold: the negative rail is good, and at least NEG_DLY ticks (default 4) have been counted since the negative rail was enabled.
- R5: In immediate mode (`delay_mode` = 0), each downstream enable rises three clock edges after the upstream good flag is set at the input, and no tick is needed.
- R6: `ready_n` goes low only when all four enables are high and the positive-rail good flag is set. It goes low one edge after the positive enable has been held high while that flag is seen as good.
- R7: After `ready_n` has gone low, a fault flag on any rail, including the positive rail itself, drives `ready_n` high.
- R8: A fault on rail i clears the enables of every rail after i at one clock edge. Rail i and the rails before it stay enabled.
- R9: Once a faulted rail's fault flag clears and its good flag is set, the downstream rails restart in order under the normal rules. A downstream rail that was re-enabled restarts its own delay count from zero.
- R10: `shdn_n` low clears all enables and drives `ready_n` high at the next edge. Releasing it restarts the whole sequence from the reference, including every delay count.
- R11: Good and fault flags pass through a two-flop synchronizer. A flag change at the input affects the outputs no earlier than the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shdn_n | input | 1 | Shutdown, active low; high allows sequencing |
| tick | input | 1 | One-cycle timing pulse counted by the delay timers |
| delay_mode | input | 1 | 1 selects delayed chaining, 0 selects immediate chaining |
| rail_good | input | 4 | Per-rail in-regulation flags (asynchronous) |
| rail_flt | input | 4 | Per-rail below-fault-threshold flags (asynchronous) |
| rail_en | output | 4 | Per-rail enables |
| ready_n | output | 1 | Supply ready, active low |

## Verification
A wrong enable or hold term shows up at the ports within three edges of the flag change that should trigger it. A rail either comes up too early, fails to come up, or stays on while an upstream rail is faulted. A delay timer that counts wrongly, fails to clear, or is compared against the wrong limit moves the rising edge of the negative or positive enable by one tick or more. That edge is checked at the exact tick and at the tick before. A stuck ready register shows up one edge after the positive rail is good, or three edges after any fault.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    localparam int unsigned NRAIL     = 4;
    localparam int unsigned RAIL_REF  = 0;
    localparam int unsigned RAIL_MAIN = 1;
    localparam int unsigned RAIL_NEG  = 2;
    localparam int unsigned RAIL_POS  = 3;

    typedef logic [NRAIL-1:0] rail_vec_t;

    // comparator flags as carried through the synchronizer
    typedef struct packed {
        rail_vec_t good;
        rail_vec_t flt;
    } rail_flags_t;

    // minimum tick count a stage must have run before its successor may start
    function automatic int unsigned stage_delay(input int unsigned idx,
                                                input int unsigned main_dly,
                                                input int unsigned neg_dly);
        if (idx == RAIL_MAIN) return main_dly;
        if (idx == RAIL_NEG)  return neg_dly;
        return 0;
    endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/rseq_stage.sv
module rseq_stage #(
    parameter int unsigned TMR_W = 5,
    parameter int unsigned DELAY = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic start,
    input  logic tick,
    input  logic delay_mode,
    output logic en,
    output logic met
);

    localparam logic [TMR_W-1:0] TMR_MAX = '1;

    logic [TMR_W-1:0] timer_q;

    // enable latches on start and stays while the upstream chain holds
    always_ff @(posedge clk) begin
        if (rst) en <= 1'b0;
        else     en <= hold & (en | start);
    end

    // saturating tick count since this stage was enabled
    always_ff @(posedge clk) begin
        if (rst || !en)                    timer_q <= '0;
        else if (tick && timer_q != TMR_MAX) timer_q <= timer_q + 1'b1;
    end

    generate
        if (DELAY == 0) begin : g_nodly
            assign met = 1'b1;
        end else begin : g_dly
            localparam logic [TMR_W-1:0] DLY_V = TMR_W'(DELAY);
            assign met = !delay_mode || (timer_q >= DLY_V);
        end
    endgenerate

    assert_timer_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (timer_q == '0));

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import rseq_pkg::*;
#(
    parameter int unsigned TMR_W    = 5,
    parameter int unsigned MAIN_DLY = 16,
    parameter int unsigned NEG_DLY  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shdn_n,
    input  logic             tick,
    input  logic             delay_mode,
    input  logic [NRAIL-1:0] rail_good,
    input  logic [NRAIL-1:0] rail_flt,
    output logic [NRAIL-1:0] rail_en,
    output logic             ready_n
);

    localparam int unsigned FLAG_W = $bits(rail_flags_t);

    rail_flags_t raw_f;
    rail_flags_t syn_f;
    logic [FLAG_W-1:0] syn_bits;
    rail_vec_t en;
    rail_vec_t met;
    rail_vec_t hold;
    rail_vec_t start;
    logic ready_q;
    logic ready_d;

    assign raw_f.good = rail_good;
    assign raw_f.flt  = rail_flt;

    rseq_sync #(.W(FLAG_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_f),
        .q   (syn_bits)
    );
    assign syn_f = rail_flags_t'(syn_bits);

    // hold: everything upstream is enabled and unfaulted; start: predecessor handed off
    always_comb begin
        logic acc;
        acc      = shdn_n;
        hold[0]  = acc;
        start[0] = 1'b1;
        for (int i = 1; i < NRAIL; i++) begin
            acc      = acc & en[i-1] & ~syn_f.flt[i-1];
            hold[i]  = acc;
            start[i] = syn_f.good[i-1] & met[i-1];
        end
    end

    generate
        for (genvar g = 0; g < NRAIL; g++) begin : g_stage
            rseq_stage #(
                .TMR_W (TMR_W),
                .DELAY (stage_delay(g, MAIN_DLY, NEG_DLY))
            ) u_stage (
                .clk        (clk),
                .rst        (rst),
                .hold       (hold[g]),
                .start      (start[g]),
                .tick       (tick),
                .delay_mode (delay_mode),
                .en         (en[g]),
                .met        (met[g])
            );
        end
    endgenerate

    assign ready_d = hold[NRAIL-1] & en[NRAIL-1] & met[NRAIL-1]
                   & syn_f.good[NRAIL-1] & ~syn_f.flt[NRAIL-1];

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= ready_d;
    end

    assign rail_en = en;
    assign ready_n = ~ready_q;

    generate
        for (genvar g = 1; g < NRAIL; g++) begin : g_chk
            assert_order_R1: assert property (@(posedge clk) disable iff (rst)
                en[g] |-> en[g-1]);
            assert_fault_R8: assert property (@(posedge clk) disable iff (rst)
                (en[g-1] && syn_f.flt[g-1]) |=> (en[NRAIL-1:g] == '0));
        end
    endgenerate

    assert_main_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(en[RAIL_MAIN]) |-> $past(syn_f.good[RAIL_REF]));

    assert_delay_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(en[RAIL_NEG]) && $past(delay_mode)) |-> $past(met[RAIL_MAIN]));

    assert_delay_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(en[RAIL_POS]) && $past(delay_mode)) |-> $past(met[RAIL_NEG] && syn_f.good[RAIL_NEG]));

    assert_ready_R6: assert property (@(posedge clk) disable iff (rst)
        !ready_n |-> (rail_en == '1));

    assert_shdn_R10: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> (rail_en == '0 && ready_n));

endmodule

// File: tb/rail_sequencer_bench.sv
`timescale 1ns/1ps
module rail_sequencer_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       shdn_n;
    logic       tick;
    logic       delay_mode;
    logic [3:0] rail_good;
    logic [3:0] rail_flt;
    logic [3:0] rail_en;
    logic       ready_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rail_sequencer u_rail_sequencer (
        .clk        (clk),
        .rst        (rst),
        .shdn_n     (shdn_n),
        .tick       (tick),
        .delay_mode (delay_mode),
        .rail_good  (rail_good),
        .rail_flt   (rail_flt),
        .rail_en    (rail_en),
        .ready_n    (ready_n)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            step(1);
            tick = 1'b0;
            step(1);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            summary();
        end
    end

    initial begin
        rst = 1'b1; shdn_n = 1'b0; tick = 1'b0; delay_mode = 1'b0;
        rail_good = 4'b0000; rail_flt = 4'b1111;
        step(4);
        check("reset rail_en", rail_en, 4'b0000);
        check("reset ready_n", ready_n, 1);
        rst = 1'b0;
        step(3);

        // ---------- immediate mode ----------
        shdn_n = 1'b1;
        step(1);
        check("R1 reference first", rail_en, 4'b0001);
        step(10);
        check("R2 main waits for reference good", rail_en, 4'b0001);
        rail_good[0] = 1'b1; rail_flt[0] = 1'b0;
        step(2);
        check("R11 no effect before third edge", rail_en, 4'b0001);
        step(1);
        check("R5 main on third edge", rail_en, 4'b0011);
        rail_good[1] = 1'b1; rail_flt[1] = 1'b0;
        step(3);
        check("R5 negative on third edge", rail_en, 4'b0111);
        rail_good[2] = 1'b1; rail_flt[2] = 1'b0;
        step(3);
        check("R5 positive on third edge", rail_en, 4'b1111);
        step(5);
        check("R6 ready waits for positive good", ready_n, 1);
        rail_good[3] = 1'b1; rail_flt[3] = 1'b0;
        step(2);
        check("R6 ready not before third edge", ready_n, 1);
        step(1);
        check("R6 ready low", ready_n, 0);

        rail_good[3] = 1'b0; rail_flt[3] = 1'b1;
        step(3);
        check("R7 positive fault releases ready", ready_n, 1);
        check("R8 positive fault keeps rails", rail_en, 4'b1111);
        rail_good[3] = 1'b1; rail_flt[3] = 1'b0;
        step(3);
        check("R9 ready back after positive recovers", ready_n, 0);

        rail_good[0] = 1'b0; rail_flt[0] = 1'b1;
        step(3);
        check("R8 reference fault drops downstream", rail_en, 4'b0001);
        check("R7 reference fault releases ready", ready_n, 1);
        rail_good[0] = 1'b1; rail_flt[0] = 1'b0;
        step(3);
        check("R9 main restarts", rail_en, 4'b0011);
        step(1);
        check("R9 negative restarts", rail_en, 4'b0111);
        step(1);
        check("R9 positive restarts", rail_en, 4'b1111);
        step(1);
        check("R9 ready restored", ready_n, 0);

        // ---------- shutdown ----------
        shdn_n = 1'b0;
        step(1);
        check("R10 shutdown clears enables", rail_en, 4'b0000);
        check("R10 shutdown releases ready", ready_n, 1);
        step(3);

        // ---------- delayed mode ----------
        delay_mode = 1'b1;
        shdn_n = 1'b1;
        step(1);
        check("R10 restart from reference", rail_en, 4'b0001);
        step(1);
        check("R2 main after reference", rail_en, 4'b0011);
        step(20);
        check("R3 negative waits without ticks", rail_en, 4'b0011);
        pulse(15);
        step(3);
        check("R3 negative not on after 15 ticks", rail_en, 4'b0011);
        pulse(1);
        step(1);
        check("R3 negative on after 16 ticks", rail_en, 4'b0111);
        pulse(3);
        step(2);
        check("R4 positive not on after 3 ticks", rail_en, 4'b0111);
        pulse(1);
        step(1);
        check("R4 positive on after 4 ticks", rail_en, 4'b1111);
        step(1);
        check("R6 ready in delayed mode", ready_n, 0);

        rail_good[1] = 1'b0; rail_flt[1] = 1'b1;
        step(2);
        check("R11 main fault not yet seen", rail_en, 4'b1111);
        step(1);
        check("R8 main fault drops negative and positive", rail_en, 4'b0011);
        check("R7 main fault releases ready", ready_n, 1);
        rail_good[1] = 1'b1; rail_flt[1] = 1'b0;
        step(3);
        check("R9 negative restarts, main delay already met", rail_en, 4'b0111);
        step(10);
        check("R9 positive waits for fresh negative delay", rail_en, 4'b0111);
        pulse(4);
        step(1);
        check("R9 positive on after 4 new ticks", rail_en, 4'b1111);

        shdn_n = 1'b0;
        step(1);
        check("R10 shutdown in delayed mode", rail_en, 4'b0000);
        shdn_n = 1'b1;
        step(2);
        check("R10 main back after release", rail_en, 4'b0011);
        step(20);
        check("R10 delay count restarted", rail_en, 4'b0011);

        done = 1'b1;
        summary();
    end

endmodule